// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs external memory cycles for a processor core over one shared address/data bus. It uses three control strobes: an address latch enable, an active-low output enable and an active-low write strobe. The core raises a request with a direction, an address and write data. The controller then spends exactly four phases (P1 to P4) on the bus. It puts the address out first, then turns the bus around. On a read it takes data in. On a write it drives data out on the same lines. It then returns the read word together with a single-cycle completion pulse.

Two address-routing modes are supported. In processor mode every access is external. In mixed mode, only addresses strictly above a configurable internal-memory limit are external. Accesses at or below the limit still produce the full strobe sequence on the pins, so the pins mirror the internal action. For those accesses the value on the external bus is discarded and the word offered by internal memory is returned instead. Address latches, decoders and the memory device sit outside the block.

Top module: `adbus_ctrl`

## Requirements
- R1: While no cycle is in progress, reqReady is 1, aleOut is 0, oeN and wrN are 1 and busOe is 0.
- R2: A request with reqValid high in a ready cycle is accepted at that clock edge. Phases P1, P2, P3 and P4 then follow on the next four clocks, one clock each.
- R3: In P1 aleOut is 1, busOe is 1 and busOut carries the accepted address. aleOut is never high for two consecutive clocks.
- R4: In P2 aleOut is 0. For a write, the address is still driven on busOut. For a read, the bus is released (busOe 0).
- R5: In P3 and P4 of a read, oeN is 0 and busOe is 0. wrN stays 1 for the whole read.
- R6: In P3 and P4 of a write, busOe is 1, busOut carries the write data, wrN is 0 and oeN is 1.
- R7: doneOut is high for exactly one clock, the clock after P4. For a read it presents the word sampled at the end of P4 on rdData. A write leaves rdData unchanged.
- R8: The routing is decided at acceptance. With extMode 0 every access is external. With extMode 1 an access is external only when reqAddr > intLimit. An internal read returns intRdata sampled at the end of P4 and ignores busIn. Strobes and bus drive are identical for internal and external cycles.
- R9: busOe and an asserted oeN (0) never occur in the same clock.
- R10: reqReady is 0 from P1 to P4. Request, mode and limit inputs changed during those phases have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core requests a bus cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Controller idle, request can be accepted |
| extMode | input | 1 | 0 = all external, 1 = mixed internal/external |
| intLimit | input | 16 | Highest internal address in mixed mode |
| intRdata | input | 16 | Word from internal memory for internal reads |
| rdData | output | 16 | Returned read word |
| doneOut | output | 1 | One-clock completion pulse |
| busIn | input | 16 | Value seen on the shared bus |
| busOut | output | 16 | Value driven onto the shared bus |
| busOe | output | 1 | Bus driver enable |
| aleOut | output | 1 | Address latch enable, active high |
| oeN | output | 1 | Memory output enable, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
External reads in processor mode confirm the address phase and the turnaround. They also show that the returned word comes from the bus, because the bus model answers with a value derived from the latched address. Writes distinguish the data phase from the address phase and show that rdData keeps its last read value. Mixed-mode reads below, at and just above the limit separate internal from external routing at the boundary, since intRdata and the bus model return different words there. One cycle has its request inputs scrambled mid-cycle to show they are ignored.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_P1   = 3'd1,
    PH_P2   = 3'd2,
    PH_P3   = 3'd3,
    PH_P4   = 3'd4
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // capture request fields
    logic ale;        // address latch enable
    logic oeN;        // memory output enable, active low
    logic wrN;        // write strobe, active low
    logic busDrive;   // enable bus driver
    logic selData;    // 1: drive write data, 0: drive address
    logic rdCapture;  // sample returned word
    logic doneSet;    // raise completion next clock
  } strobe_t;

endpackage

// File: rtl/adbus_ctrl_fsm.sv
module adbus_ctrl_fsm
  import adbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  phase_t phase;
  logic   isWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      isWrite <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (reqValid) begin
          phase   <= PH_P1;
          isWrite <= reqWrite;
        end
        PH_P1:   phase <= PH_P2;
        PH_P2:   phase <= PH_P3;
        PH_P3:   phase <= PH_P4;
        PH_P4:   phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    stb = '{load: 1'b0, ale: 1'b0, oeN: 1'b1, wrN: 1'b1, busDrive: 1'b0,
            selData: 1'b0, rdCapture: 1'b0, doneSet: 1'b0};
    reqReady = (phase == PH_IDLE);
    unique case (phase)
      PH_IDLE: stb.load = reqValid;
      PH_P1: begin
        stb.ale      = 1'b1;
        stb.busDrive = 1'b1;
      end
      PH_P2: stb.busDrive = isWrite;  // read: turnaround phase
      PH_P3, PH_P4: begin
        if (isWrite) begin
          stb.busDrive = 1'b1;
          stb.selData  = 1'b1;
          stb.wrN      = 1'b0;
        end else begin
          stb.oeN = 1'b0;
        end
        if (phase == PH_P4) begin
          stb.rdCapture = !isWrite;
          stb.doneSet   = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/adbus_datapath.sv
module adbus_datapath
  import adbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              extMode,
  input  logic [DATA_W-1:0] intLimit,
  input  logic [DATA_W-1:0] intRdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              aleOut,
  output logic              oeN,
  output logic              wrN,
  output logic [DATA_W-1:0] rdData,
  output logic              doneOut
);

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              extQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      extQ    <= 1'b1;
      rdData  <= '0;
      doneOut <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        extQ   <= !extMode || (reqAddr > intLimit);
      end
      if (stb.rdCapture) rdData <= extQ ? busIn : intRdata;
      doneOut <= stb.doneSet;
    end
  end

  assign busOut = stb.selData ? wdataQ : addrQ;
  assign busOe  = stb.busDrive;
  assign aleOut = stb.ale;
  assign oeN    = stb.oeN;
  assign wrN    = stb.wrN;

endmodule

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
  import adbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              extMode,
  input  logic [DATA_W-1:0] intLimit,
  input  logic [DATA_W-1:0] intRdata,
  output logic [DATA_W-1:0] rdData,
  output logic              doneOut,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              aleOut,
  output logic              oeN,
  output logic              wrN
);

  strobe_t stb;

  adbus_ctrl_fsm u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  adbus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .extMode(extMode), .intLimit(intLimit), .intRdata(intRdata), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .aleOut(aleOut), .oeN(oeN), .wrN(wrN),
    .rdData(rdData), .doneOut(doneOut)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!aleOut && oeN && wrN && !busOe));

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> aleOut);

  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> !aleOut);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !wrN));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !busOe);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |-> !reqReady);

endmodule

// File: tb/tb_adbus_ctrl.sv
module tb_adbus_ctrl;

  localparam int W = 16;
  localparam logic [W-1:0] MEMKEY = 16'h5A3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, extMode = 1'b0;
  logic [W-1:0] reqAddr = '0, reqWdata = '0, intLimit = '0, intRdata = '0;
  logic reqReady, doneOut, busOe, aleOut, oeN, wrN;
  logic [W-1:0] rdData, busOut, busIn, latAddr;

  int checks = 0, failures = 0;
  logic [W-1:0] expQ[$];
  logic [W-1:0] prevRd = '0;

  always #4 clk = ~clk;

  adbus_ctrl #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .extMode(extMode), .intLimit(intLimit), .intRdata(intRdata),
    .rdData(rdData), .doneOut(doneOut), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .aleOut(aleOut), .oeN(oeN), .wrN(wrN)
  );

  // External memory model: latch address on ALE, answer while OE low
  always @(negedge clk) if (aleOut) latAddr <= busOut;
  assign busIn = oeN ? 16'h0000 : (latAddr ^ MEMKEY);

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected read word at each completion pulse (R7)
  always @(negedge clk) begin
    if (rstN && doneOut) begin
      if (expQ.size() == 0) chk(1'b0, "R7 unexpected done", 16'h1, 16'h0);
      else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R7/R8 rdData", rdData, e);
      end
    end
  end

  task automatic doReq(input bit wr, input logic [W-1:0] addr,
                       input logic [W-1:0] wd, input bit mode,
                       input logic [W-1:0] lim, input logic [W-1:0] iv,
                       input bit scramble);
    bit ext;
    logic [W-1:0] e;
    ext = !mode || (addr > lim);
    e = wr ? prevRd : (ext ? (addr ^ MEMKEY) : iv);
    if (!wr) prevRd = e;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    extMode = mode; intLimit = lim; intRdata = iv;
    @(negedge clk);  // P1
    chk(aleOut && busOe && busOut == addr, "R3 P1 address", busOut, addr);
    chk(!reqReady, "R10 busy in P1", {15'd0, reqReady}, 16'h0);
    reqValid = 1'b0;
    if (scramble) begin  // R10: inputs changed mid-cycle are ignored
      reqWrite = !wr; reqAddr = ~addr; reqWdata = ~wd; extMode = !mode;
      intLimit = ~lim;
    end
    @(negedge clk);  // P2
    if (wr) chk(!aleOut && busOe && busOut == addr && oeN && wrN,
                "R4 P2 write holds address", busOut, addr);
    else    chk(!aleOut && !busOe && oeN && wrN, "R4 P2 read released",
                {15'd0, busOe}, 16'h0);
    for (int p = 3; p <= 4; p++) begin
      @(negedge clk);  // P3, P4
      if (wr) chk(busOe && busOut == wd && !wrN && oeN && !aleOut,
                  "R6 write data phase", busOut, wd);
      else    chk(!busOe && !oeN && wrN && !aleOut,
                  "R5 read enable phase", {oeN, wrN, busOe}, 16'h2);
      chk(!reqReady, "R2 still busy", {15'd0, reqReady}, 16'h0);
    end
    @(negedge clk);  // completion cycle
    chk(doneOut, "R2/R7 done after P4", {15'd0, doneOut}, 16'h1);
    chk(reqReady && !aleOut && oeN && wrN && !busOe, "R1 idle after cycle",
        {aleOut, oeN, wrN, busOe}, 16'h6);
    @(negedge clk);
    chk(!doneOut, "R7 single pulse", {15'd0, doneOut}, 16'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        chk(reqReady && !aleOut && oeN && wrN && !busOe && !doneOut,
            "R1 reset state", {aleOut, oeN, wrN, busOe}, 16'h6);
        // Processor mode: all external (R8)
        doReq(1'b0, 16'h1234, 16'h0, 1'b0, 16'hFFFF, 16'hBEEF, 1'b0);
        doReq(1'b1, 16'h0040, 16'hC0DE, 1'b0, 16'h0FFF, 16'hBEEF, 1'b0);
        doReq(1'b0, 16'h0800, 16'h0, 1'b0, 16'h0FFF, 16'hBEEF, 1'b0);
        // Mixed mode: boundary around limit (R8)
        doReq(1'b0, 16'h0800, 16'h0, 1'b1, 16'h0FFF, 16'hBEEF, 1'b0);
        doReq(1'b0, 16'h0FFF, 16'h0, 1'b1, 16'h0FFF, 16'h7777, 1'b0);
        doReq(1'b0, 16'h1000, 16'h0, 1'b1, 16'h0FFF, 16'h7777, 1'b0);
        doReq(1'b1, 16'h0010, 16'hA55A, 1'b1, 16'h0FFF, 16'h7777, 1'b0);
        // R10: scrambled inputs mid-cycle
        doReq(1'b0, 16'hF00D, 16'h0, 1'b1, 16'h0FFF, 16'h1111, 1'b1);
        doReq(1'b1, 16'h2222, 16'h3333, 1'b0, 16'h0000, 16'h1111, 1'b1);
        chk(expQ.size() == 0, "R7 all completions seen", 16'(expQ.size()), 16'h0);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 16'h0, 16'h1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule